// File: doc/BRIEF.md
# Divide-by-Twelve Two-Section Counter

This block is a four-bit counter split into two independent sections. The first section is a single toggle stage (output A) that divides its own count input by two. The second section holds outputs B, C and D. Its B/C pair is a divide-by-three, and D toggles each time C returns to zero, so the section divides its own count input by six and skips the binary codes 011 and 111. Both sections move on the falling edge of their count inputs. The count inputs are plain signals sampled on one system clock, not clocks.

Joining output A to the second section gives a divide-by-twelve counter. This can be done inside the block with a parameter, or outside it by tying the A output back to the second count input. With the parameter set, the second section's count input is not used. A pair of clear inputs forms an AND gate. Only when both are high are all four outputs forced to zero, and counting is frozen while that lasts. The clear and the system reset take effect at once. Both are released in step with the clock.

Top module: `div12_ripple_counter`

## Requirements
- R1: While `rst_ni` is low, all four outputs are 0.
- R2: While `clr_a_i` and `clr_b_i` are both 1, all four outputs are 0. With only one of them at 1, counting goes on unchanged.
- R3: While both clear inputs are 1, falling edges on either count input are ignored, so the state is 0 after release. A falling edge first sampled on or after the third rising clock edge after release is counted.
- R4: Output A toggles once for each falling edge of `cnt_a_i`. It changes on the first rising clock edge where the input is sampled low after being sampled high. Rising edges of the input do not change it.
- R5: With `LINK_A_TO_BCD` = 0, successive falling edges of `cnt_bcd_i` step {D,C,B} through 000, 001, 010, 100, 101, 110 and then back to 000.
- R6: With `LINK_A_TO_BCD` = 0 and no external tie, pulses on `cnt_a_i` never change B, C or D, and pulses on `cnt_bcd_i` never change A.
- R7: When chained, either by `LINK_A_TO_BCD` = 1 or by tying `q_a_o` to `cnt_bcd_i`, falling edges on `cnt_a_i` step {D,C,B,A} through 0000, 0001, 0010, 0011, 0100, 0101, 1000, 1001, 1010, 1011, 1100, 1101 and then wrap to 0000. With `LINK_A_TO_BCD` = 1, `cnt_bcd_i` has no effect.
- R8: Chained, 24 input pulses give 12 rising edges on A, 4 on C and 2 on D. Unchained, 12 pulses on `cnt_bcd_i` give 4 rising edges on C and 2 on D.
- R9: With `LINK_A_TO_BCD` = 1, B, C and D update on the same clock edge at which A falls from 1 to 0, so no intermediate code appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_a_i | input | 1 | First clear input, active high when paired with the second |
| clr_b_i | input | 1 | Second clear input |
| cnt_a_i | input | 1 | Count input of the divide-by-two section |
| cnt_bcd_i | input | 1 | Count input of the divide-by-six section |
| q_a_o | output | 1 | Divide-by-two output |
| q_b_o | output | 1 | Low bit of the divide-by-three pair |
| q_c_o | output | 1 | High bit of the divide-by-three pair |
| q_d_o | output | 1 | Toggle stage after the divide-by-three pair |

## Verification
A corrupted divide-by-three pair shows up at once as C and B both high, a code the section must never hold. A mistimed D toggle shows as a {D,C,B} value that disagrees with the model on the very next pulse. A toggle stage that misses or doubles an edge changes A at the clock edge after the falling input, and the error carries into every later code of the chained sequence. A missing or mis-synchronised clear shows as a nonzero state on the first check after release. An internal link that lags by a cycle shows one cycle after A falls.

// File: rtl/div12_pkg.sv
package div12_pkg;

  // States of the divide-by-three pair, encoded as {C,B}
  typedef enum logic [1:0] {
    TRI_0 = 2'b00,
    TRI_1 = 2'b01,
    TRI_2 = 2'b10
  } tri_state_e;

  localparam int unsigned TRI_W = 2;

  // Next state of the divide-by-three pair
  function automatic tri_state_e tri_step(input tri_state_e cur);
    tri_state_e nxt;
    case (cur)
      TRI_0:   nxt = TRI_1;
      TRI_1:   nxt = TRI_2;
      default: nxt = TRI_0;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/div12_rst_sync.sv
module div12_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_a_i,
  input  logic clr_b_i,
  output logic rst_n_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic              raw_n;
  logic [LAST:0]     sh_q;
  logic [LAST:0]     sh_d;

  // Gated clear: both inputs high, or system reset low
  always_comb begin
    raw_n = rst_ni & ~(clr_a_i & clr_b_i);
  end

  always_comb begin
    sh_d = {sh_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge raw_n) begin
    if (!raw_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  // Immediate assertion through raw_n, clocked release through the shifter
  always_comb begin
    rst_n_o = sh_q[LAST] & raw_n;
  end

endmodule

// File: rtl/div12_fall_det.sv
module div12_fall_det #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = sig_i;
    fall_o = prev_q & ~sig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/div12_stage_a.sv
module div12_stage_a (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_o,
  output logic wrap_o
);
  logic a_q;
  logic a_d;

  always_comb begin
    a_d    = adv_i ? ~a_q : a_q;
    wrap_o = adv_i & a_q;
    q_o    = a_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
    end else if (adv_i) begin
      a_q <= a_d;
    end
  end

endmodule

// File: rtl/div12_stage_bcd.sv
module div12_stage_bcd
  import div12_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output logic q_b_o,
  output logic q_c_o,
  output logic q_d_o
);
  tri_state_e tri_q;
  tri_state_e tri_d;
  logic       d_q;
  logic       d_d;
  logic       c_fall;

  always_comb begin
    tri_d  = adv_i ? tri_step(tri_q) : tri_q;
    // C drops from 1 to 0 exactly when the pair wraps from TRI_2
    c_fall = adv_i & (tri_q == TRI_2);
    d_d    = c_fall ? ~d_q : d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tri_q <= TRI_0;
    end else if (adv_i) begin
      tri_q <= tri_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= 1'b0;
    end else if (c_fall) begin
      d_q <= d_d;
    end
  end

  always_comb begin
    {q_c_o, q_b_o} = tri_q;
    q_d_o          = d_q;
  end

endmodule

// File: rtl/div12_ripple_counter.sv
module div12_ripple_counter #(
  parameter bit          LINK_A_TO_BCD = 1'b0,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic cnt_a_i,
  input  logic cnt_bcd_i,
  output logic q_a_o,
  output logic q_b_o,
  output logic q_c_o,
  output logic q_d_o
);
  localparam int unsigned N_CNT = 2;

  logic             rst_int_n;
  logic [N_CNT-1:0] cnt_vec;
  logic [N_CNT-1:0] fall_vec;
  logic             a_wrap;
  logic             bcd_adv;

  div12_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_a_i (clr_a_i),
    .clr_b_i (clr_b_i),
    .rst_n_o (rst_int_n)
  );

  always_comb begin
    cnt_vec = {cnt_bcd_i, cnt_a_i};
  end

  div12_fall_det #(
    .WIDTH (N_CNT)
  ) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .sig_i  (cnt_vec),
    .fall_o (fall_vec)
  );

  div12_stage_a u_a (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .adv_i  (fall_vec[0]),
    .q_o    (q_a_o),
    .wrap_o (a_wrap)
  );

  // Source of the divide-by-six advance chosen by the mode parameter
  always_comb begin
    if (LINK_A_TO_BCD) begin
      bcd_adv = a_wrap;
    end else begin
      bcd_adv = fall_vec[1];
    end
  end

  div12_stage_bcd u_bcd (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .adv_i  (bcd_adv),
    .q_b_o  (q_b_o),
    .q_c_o  (q_c_o),
    .q_d_o  (q_d_o)
  );

endmodule

// File: rtl/div12_ripple_counter_chk.sv
module div12_ripple_counter_chk #(
  parameter bit LINK_A_TO_BCD = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rst_int_n,
  input logic clr_a_i,
  input logic clr_b_i,
  input logic cnt_a_i,
  input logic q_a_o,
  input logic q_b_o,
  input logic q_c_o,
  input logic q_d_o
);

  // R1
  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> ({q_d_o, q_c_o, q_b_o, q_a_o} == 4'b0000));

  // R2
  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_a_i && clr_b_i) |-> ({q_d_o, q_c_o, q_b_o, q_a_o} == 4'b0000));

  // R4: no falling edge, no change of A
  a_r4_a_hold: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !$fell(cnt_a_i) |=> $stable(q_a_o));

  // R4: a falling edge outside reset toggles A
  a_r4_a_toggle: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (rst_int_n && $past(rst_int_n) && $fell(cnt_a_i)) |=> (q_a_o != $past(q_a_o)));

  // R5: the divide-by-three pair never holds C and B high together
  a_r5_no_skipped_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q_c_o && q_b_o));

  generate
    if (LINK_A_TO_BCD) begin : g_link
      // R9
      a_r9_same_edge: assert property (@(posedge clk_i) disable iff (!rst_int_n)
        (rst_int_n && $fell(q_a_o)) |-> !$stable({q_d_o, q_c_o, q_b_o}));
    end
  endgenerate

endmodule

bind div12_ripple_counter div12_ripple_counter_chk #(
  .LINK_A_TO_BCD (LINK_A_TO_BCD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rst_int_n (rst_int_n),
  .clr_a_i   (clr_a_i),
  .clr_b_i   (clr_b_i),
  .cnt_a_i   (cnt_a_i),
  .q_a_o     (q_a_o),
  .q_b_o     (q_b_o),
  .q_c_o     (q_c_o),
  .q_d_o     (q_d_o)
);

// File: tb/div12_ripple_counter_tb_top.sv
module div12_ripple_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       clr_a;
  logic       clr_b;
  logic       cnt_a;
  logic       bcd_drv;
  logic       tie;
  logic       cnt_bcd_s;
  logic [3:0] q_s;  // {D,C,B,A} of the unlinked instance
  logic [3:0] q_l;  // {D,C,B,A} of the linked instance

  int checks;
  int fails;
  bit done;

  // Bench models: A bit and divide-by-six index
  int s_a, s_m, l_a, l_m;

  assign cnt_bcd_s = tie ? q_s[0] : bcd_drv;

  div12_ripple_counter #(.LINK_A_TO_BCD(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .cnt_a_i(cnt_a), .cnt_bcd_i(cnt_bcd_s),
    .q_a_o(q_s[0]), .q_b_o(q_s[1]), .q_c_o(q_s[2]), .q_d_o(q_s[3]));

  div12_ripple_counter #(.LINK_A_TO_BCD(1'b1)) dut_link_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_a_i(clr_a), .clr_b_i(clr_b),
    .cnt_a_i(cnt_a), .cnt_bcd_i(bcd_drv),
    .q_a_o(q_l[0]), .q_b_o(q_l[1]), .q_c_o(q_l[2]), .q_d_o(q_l[3]));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] enc(input int a, input int m);
    logic [2:0] bcd;
    bcd = (m < 3) ? 3'(m) : 3'(m + 1);
    return {bcd, a[0]};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    check({tag, " unlinked"}, q_s, enc(s_a, s_m));
    check({tag, " linked"}, q_l, enc(l_a, l_m));
  endtask

  task automatic pulse_a(input int hi, input int lo);
    bit frozen;
    frozen = clr_a && clr_b;
    cnt_a = 1'b1;
    tick(hi);
    cnt_a = 1'b0;
    tick(lo);
    if (!frozen) begin
      if (s_a == 1 && tie) s_m = (s_m + 1) % 6;
      s_a ^= 1;
      if (l_a == 1) l_m = (l_m + 1) % 6;
      l_a ^= 1;
    end
  endtask

  task automatic pulse_b(input int hi, input int lo);
    bit frozen;
    frozen = clr_a && clr_b;
    bcd_drv = 1'b1;
    tick(hi);
    bcd_drv = 1'b0;
    tick(lo);
    if (!frozen && !tie) s_m = (s_m + 1) % 6;
  endtask

  task automatic clear_pulse();
    clr_a = 1'b1;
    clr_b = 1'b1;
    tick(1);
    check("R2 both clears high", q_s, 4'b0000);
    check("R2 both clears high linked", q_l, 4'b0000);
    pulse_a(1, 2);
    pulse_b(1, 2);
    check("R3 count ignored in clear", q_s, 4'b0000);
    clr_a = 1'b0;
    clr_b = 1'b0;
    s_a = 0; s_m = 0; l_a = 0; l_m = 0;
    tick(4);
    check_all("R3 state after release");
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ra, rc, rd, la, lc, ld;
    logic [3:0] ps, pl;
    checks = 0; fails = 0; done = 1'b0;
    s_a = 0; s_m = 0; l_a = 0; l_m = 0;
    rst_n = 1'b1; clr_a = 1'b0; clr_b = 1'b0;
    cnt_a = 1'b0; bcd_drv = 1'b0; tie = 1'b0;
    void'($urandom(32'd20240917));
    #2 rst_n = 1'b0;
    tick(2);
    pulse_a(1, 2);
    check("R1 reset state", q_s, 4'b0000);
    check("R1 reset state linked", q_l, 4'b0000);
    s_a = 0; l_a = 0;
    rst_n = 1'b1;
    tick(4);
    check_all("R1 after release");

    // R4: rising edge alone does nothing, fall acts on next edge
    cnt_a = 1'b1;
    tick(3);
    check("R4 rising edge ignored", q_s, 4'b0000);
    cnt_a = 1'b0;
    tick(1);
    s_a = 1; l_a = 1;
    check("R4 toggle one edge after fall", q_s, enc(1, 0));
    tick(2);

    // R6: unlinked sections stay apart
    pulse_a(2, 2);
    check("R6 A pulses leave BCD", {q_s[3:1], 1'b0}, 4'b0000);
    pulse_a(1, 2);
    pulse_b(1, 2);
    check("R6 BCD pulse leaves A", {3'b000, q_s[0]}, 4'b0001);
    check_all("R6 after mixed pulses");

    // R5 sequence on the unlinked instance, R7 ignore on linked
    clear_pulse();
    for (int i = 1; i <= 7; i++) begin
      pulse_b(2, 2);
      check("R5 bcd sequence", q_s, enc(0, i % 6));
    end
    check("R7 linked ignores bcd input", q_l, 4'b0000);

    // R8 unlinked rates
    clear_pulse();
    rc = 0; rd = 0;
    for (int i = 0; i < 12; i++) begin
      ps = q_s;
      pulse_b(1, 2);
      if (!ps[2] && q_s[2]) rc++;
      if (!ps[3] && q_s[3]) rd++;
    end
    check_int("R8 C rises divide-by-six mode", rc, 4);
    check_int("R8 D rises divide-by-six mode", rd, 2);

    // R7/R8 chained through external tie and through parameter
    clear_pulse();
    tie = 1'b1;
    ra = 0; rc = 0; rd = 0; la = 0; lc = 0; ld = 0;
    for (int i = 1; i <= 24; i++) begin
      ps = q_s; pl = q_l;
      pulse_a(1, 3);
      check("R7 chained sequence tie", q_s, enc(i % 2, (i / 2) % 6));
      check("R7 chained sequence link", q_l, enc(i % 2, (i / 2) % 6));
      if (!ps[0] && q_s[0]) ra++;
      if (!ps[2] && q_s[2]) rc++;
      if (!ps[3] && q_s[3]) rd++;
      if (!pl[0] && q_l[0]) la++;
      if (!pl[2] && q_l[2]) lc++;
      if (!pl[3] && q_l[3]) ld++;
    end
    check_int("R8 A rises tie", ra, 12);
    check_int("R8 C rises tie", rc, 4);
    check_int("R8 D rises tie", rd, 2);
    check_int("R8 A rises link", la, 12);
    check_int("R8 C rises link", lc, 4);
    check_int("R8 D rises link", ld, 2);

    // R9: linked BCD moves on the same edge as A falls
    clear_pulse();
    for (int i = 0; i < 5; i++) pulse_a(1, 2);
    cnt_a = 1'b1;
    tick(2);
    cnt_a = 1'b0;
    tick(1);
    check("R9 same edge 0101->1000", q_l, 4'b1000);
    tick(1);
    s_a = 0; s_m = 3; l_a = 0; l_m = 3;
    for (int i = 0; i < 5; i++) pulse_a(1, 2);
    cnt_a = 1'b1;
    tick(2);
    cnt_a = 1'b0;
    tick(1);
    check("R9 same edge wrap to 0000", q_l, 4'b0000);
    tick(2);
    s_a = 0; s_m = 0; l_a = 0; l_m = 0;
    check_all("R7 wrap after twelve");

    // R2: a single clear input does not stop counting
    clr_a = 1'b1;
    pulse_a(1, 2);
    check_all("R2 only first clear high");
    clr_a = 1'b0;
    clr_b = 1'b1;
    pulse_a(1, 2);
    check_all("R2 only second clear high");
    clr_b = 1'b0;
    tick(1);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op == 0) begin
        clear_pulse();
        tie = 1'($urandom % 2);
      end else if (op == 1) begin
        if ($urandom % 2) clr_a = 1'b1; else clr_b = 1'b1;
        pulse_a(1 + int'($urandom % 3), 2 + int'($urandom % 3));
        clr_a = 1'b0;
        clr_b = 1'b0;
        check_all("R2 random single clear");
      end else if (op <= 4) begin
        pulse_b(1 + int'($urandom % 3), 2 + int'($urandom % 3));
        check_all(tie ? "R7 random bcd pulse tied" : "R5 random bcd pulse");
      end else begin
        pulse_a(1 + int'($urandom % 3), 2 + int'($urandom % 3));
        check_all(tie ? "R7 random A pulse" : "R6 random A pulse");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule